// File: doc/BRIEF.md
# Receive Polarity Detect-and-Correct Controller

This block decides the polarity of the receive pair on a 10 Mb/s twisted-pair port and corrects the received data to match. A packet strobe arrives once per received packet. It comes with two flags. One says whether the end-of-transmission delimiter of that packet qualified as valid. The other says whether the delimiter was seen inverted. The analog pulse checks and the delimiter detection sit upstream and deliver these as clean digital pulses.

After reset, or after a link-fail event, the controller is armed. The first packet with a valid delimiter sets the inversion control to the polarity seen on that delimiter, whatever the setting was before. Further valid packets that agree with the decision add to a run count. A valid packet that disagrees replaces the decision and starts the run again. When the run reaches the confirmation count (two by default), the decision locks. It then holds until link fail or reset. The inversion control XORs the incoming data bits. A status bit copies the inversion for software or an LED. A lock flag shows when the decision has been confirmed.

Top module: `rx_pol_ctrl`

## Requirements
- R1: Reset is synchronous and active high. During and after reset, `rx_invert`, `pol_reversed` and `pol_locked` are 0, and the controller is armed with an empty run.
- R2: While armed with an empty run, a strobe with `etd_valid`=1 sets `rx_invert` to `etd_inverted` (1 = inverted) on the clock edge of that strobe, whatever the previous value was.
- R3: A valid packet whose `etd_inverted` equals the current `rx_invert` extends the run. `pol_locked` goes to 1 on the edge of the strobe that brings the run to CONFIRM_CNT. The default CONFIRM_CNT is 2.
- R4: While armed, a valid packet whose `etd_inverted` differs from `rx_invert` sets `rx_invert` to the new polarity and restarts the run at one. CONFIRM_CNT−1 further matching packets are then needed to lock.
- R5: A strobe with `etd_valid`=0 changes neither `rx_invert`, the run count nor `pol_locked`. Cycles without a strobe change nothing either.
- R6: While locked, valid packets of either polarity leave `rx_invert` and `pol_locked` unchanged.
- R7: `link_fail` high on a clock edge clears `pol_locked` and empties the run. It keeps the current `rx_invert` until the next valid packet. If a strobe falls in the same cycle as `link_fail`, the link fail wins and that packet is discarded.
- R8: `pol_reversed` is 1 exactly when `rx_invert` is 1.
- R9: `rx_data_out` equals `rx_data_in` with every bit XORed with `rx_invert`, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_stb | input | 1 | One-cycle pulse per received packet |
| etd_valid | input | 1 | Delimiter of this packet qualified as valid |
| etd_inverted | input | 1 | Delimiter seen with inverted polarity |
| link_fail | input | 1 | Link-fail condition, re-arms the controller |
| rx_data_in | input | DATA_W | Raw received data bits |
| rx_data_out | output | DATA_W | Polarity-corrected data bits |
| rx_invert | output | 1 | Inversion control applied to the data |
| pol_locked | output | 1 | Polarity decision confirmed and locked |
| pol_reversed | output | 1 | Status: receive pair is reversed |

## Verification
Two functions can meet in one cycle. A packet strobe can update the decision while a link fail re-arms the controller, and the two pull the state in opposite directions. The bench locks an inverted decision, then raises `link_fail` in the same cycle as a valid strobe of opposite polarity. It judges that the lock clears while `rx_invert` stays 1, so the packet was discarded. A following valid packet must then set the polarity unconditionally, without locking.

// File: rtl/rx_pol_pkg.sv
package rx_pol_pkg;

    // Default number of consecutive agreeing valid packets needed to lock.
    localparam int unsigned DEF_CONFIRM = 2;

    // One delimiter event as seen by the decision logic.
    typedef struct packed {
        logic stb;
        logic valid;
        logic inverted;
    } etd_evt_t;

    // Decision state carried between packets.
    typedef struct packed {
        logic invert;
        logic locked;
    } pol_dec_t;

    // True when the event may update the decision.
    function automatic logic evt_usable(etd_evt_t e, logic locked);
        return e.stb && e.valid && !locked;
    endfunction

endpackage

// File: rtl/rx_pol_decide.sv
module rx_pol_decide
    import rx_pol_pkg::*;
#(
    parameter int unsigned CONFIRM_CNT = DEF_CONFIRM
) (
    input  logic     clk,
    input  logic     rst,
    input  etd_evt_t evt,
    input  logic     link_fail,
    output pol_dec_t dec
);
    localparam int unsigned CNT_W = $clog2(CONFIRM_CNT + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CONFIRM_CNT);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] run_nxt;
    logic             use_evt;
    logic             agrees;

    assign use_evt = evt_usable(evt, dec.locked);
    assign agrees  = (run_cnt != '0) && (evt.inverted == dec.invert);
    assign run_nxt = agrees ? run_cnt + CNT_ONE : CNT_ONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            dec.invert <= 1'b0;
            dec.locked <= 1'b0;
            run_cnt    <= '0;
        end else if (link_fail) begin
            dec.locked <= 1'b0;
            run_cnt    <= '0;
        end else if (use_evt) begin
            dec.invert <= evt.inverted;
            run_cnt    <= run_nxt;
            dec.locked <= (run_nxt == CNT_TOP);
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!dec.invert && !dec.locked && run_cnt == '0));

    // R2
    first_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (run_cnt == '0 && evt.stb && evt.valid && !link_fail)
        |=> (dec.invert == $past(evt.inverted)));

    // R5
    invalid_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!(evt.stb && evt.valid) && !link_fail)
        |=> ($stable(dec.invert) && $stable(run_cnt) && $stable(dec.locked)));

    // R6
    lock_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (dec.locked && !link_fail) |=> (dec.locked && $stable(dec.invert)));

    // R7
    link_fail_chk: assert property (@(posedge clk) disable iff (rst)
        link_fail |=> (!dec.locked && run_cnt == '0 && $stable(dec.invert)));

    // R3
    run_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= CNT_TOP);

endmodule

// File: rtl/rx_pol_xor.sv
module rx_pol_xor #(
    parameter int unsigned DATA_W = 1
) (
    input  logic [DATA_W-1:0] din,
    input  logic              invert,
    output logic [DATA_W-1:0] dout
);
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign dout[b] = din[b] ^ invert;
    end
endmodule

// File: rtl/rx_pol_ctrl.sv
module rx_pol_ctrl
    import rx_pol_pkg::*;
#(
    parameter int unsigned CONFIRM_CNT = DEF_CONFIRM,
    parameter int unsigned DATA_W      = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_stb,
    input  logic              etd_valid,
    input  logic              etd_inverted,
    input  logic              link_fail,
    input  logic [DATA_W-1:0] rx_data_in,
    output logic [DATA_W-1:0] rx_data_out,
    output logic              rx_invert,
    output logic              pol_locked,
    output logic              pol_reversed
);
    etd_evt_t evt;
    pol_dec_t dec;

    assign evt = '{stb: pkt_stb, valid: etd_valid, inverted: etd_inverted};

    rx_pol_decide #(.CONFIRM_CNT(CONFIRM_CNT)) u_decide (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .link_fail (link_fail),
        .dec       (dec)
    );

    rx_pol_xor #(.DATA_W(DATA_W)) u_xor (
        .din    (rx_data_in),
        .invert (dec.invert),
        .dout   (rx_data_out)
    );

    assign rx_invert    = dec.invert;
    assign pol_locked   = dec.locked;
    assign pol_reversed = dec.invert;

    // R9
    data_path_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_data_out != rx_data_in) |-> rx_invert);

endmodule

// File: tb/rx_pol_ctrl_test.sv
module rx_pol_ctrl_test;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst, pkt_stb, etd_valid, etd_inverted, link_fail;
    logic [DW-1:0] rx_data_in, rx_data_out;
    logic          rx_invert, pol_locked, pol_reversed;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rx_pol_ctrl #(.CONFIRM_CNT(2), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .pkt_stb(pkt_stb), .etd_valid(etd_valid),
        .etd_inverted(etd_inverted), .link_fail(link_fail),
        .rx_data_in(rx_data_in), .rx_data_out(rx_data_out),
        .rx_invert(rx_invert), .pol_locked(pol_locked),
        .pol_reversed(pol_reversed)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req, input logic inv, input logic lk);
        chk({req, " rx_invert"}, DW'(rx_invert), DW'(inv));
        chk({req, " pol_locked"}, DW'(pol_locked), DW'(lk));
        chk("R8 pol_reversed", DW'(pol_reversed), DW'(inv));
    endtask

    // Inputs change at negedge; the update lands on the next posedge and is read at the following negedge.
    task automatic pkt(input logic ok, input logic inv, input logic lf);
        pkt_stb = 1'b1; etd_valid = ok; etd_inverted = inv; link_fail = lf;
        @(negedge clk);
        pkt_stb = 1'b0; etd_valid = 1'b0; etd_inverted = 1'b0; link_fail = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk_state("R1", 1'b0, 1'b0);
    endtask

    task automatic t_first_and_lock();
        do_reset();
        pkt(1, 1, 0);
        chk_state("R2 first", 1'b1, 1'b0);
        pkt(1, 1, 0);
        chk_state("R3 lock", 1'b1, 1'b1);
    endtask

    task automatic t_disagree();
        do_reset();
        pkt(1, 0, 0);
        chk_state("R2 first normal", 1'b0, 1'b0);
        pkt(1, 1, 0);
        chk_state("R4 flip", 1'b1, 1'b0);
        pkt(1, 0, 0);
        chk_state("R4 flip back", 1'b0, 1'b0);
        pkt(1, 0, 0);
        chk_state("R4 relock", 1'b0, 1'b1);
    endtask

    task automatic t_invalid();
        do_reset();
        pkt(0, 1, 0);
        chk_state("R5 invalid on empty", 1'b0, 1'b0);
        pkt(1, 1, 0);
        pkt(0, 0, 0);
        chk_state("R5 invalid after first", 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        chk_state("R5 idle cycles", 1'b1, 1'b0);
        pkt(1, 1, 0);
        chk_state("R5 run kept", 1'b1, 1'b1);
    endtask

    task automatic t_locked_hold();
        do_reset();
        pkt(1, 1, 0);
        pkt(1, 1, 0);
        pkt(1, 0, 0);
        chk_state("R6 opposite ignored", 1'b1, 1'b1);
        pkt(1, 0, 0);
        chk_state("R6 still held", 1'b1, 1'b1);
        do_reset();
        chk_state("R1 reset clears lock", 1'b0, 1'b0);
    endtask

    task automatic t_link_fail();
        do_reset();
        pkt(1, 1, 0);
        pkt(1, 1, 0);
        link_fail = 1'b1;
        @(negedge clk);
        link_fail = 1'b0;
        chk_state("R7 unlock keep", 1'b1, 1'b0);
        pkt(1, 0, 0);
        chk_state("R7 rearmed sets", 1'b0, 1'b0);
        pkt(1, 0, 0);
        chk_state("R7 relock", 1'b0, 1'b1);
    endtask

    task automatic t_collide();
        do_reset();
        pkt(1, 1, 0);
        pkt(1, 1, 0);
        pkt(1, 0, 1);
        chk_state("R7 same-cycle discard", 1'b1, 1'b0);
        pkt(1, 0, 0);
        chk_state("R7 after collide first", 1'b0, 1'b0);
    endtask

    task automatic t_datapath();
        do_reset();
        rx_data_in = 4'b1010;
        #1;
        chk("R9 normal", rx_data_out, 4'b1010);
        pkt(1, 1, 0);
        rx_data_in = 4'b0110;
        #1;
        chk("R9 inverted", rx_data_out, 4'b1001);
        rx_data_in = 4'b1111;
        #1;
        chk("R9 inverted all ones", rx_data_out, 4'b0000);
    endtask

    initial begin
        rst = 1'b1; pkt_stb = 0; etd_valid = 0; etd_inverted = 0; link_fail = 0;
        rx_data_in = '0;
        @(negedge clk);
        t_reset();
        t_first_and_lock();
        t_disagree();
        t_invalid();
        t_locked_hold();
        t_link_fail();
        t_collide();
        t_datapath();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule